// File: doc/BRIEF.md
# Board Trigger Selector with Post-Trigger Stop Delay

This block decides when a multi-channel sampling board has seen its trigger and when it must freeze its circular sample memory. Every analog channel has a comparator against one shared threshold; the comparator outputs reach this block as asynchronous levels. An enable mask picks which channels take part, and any single enabled channel or any OR of several can fire. A configuration bit can instead route an external trigger input as the only source.

Once armed, the block accepts the first rising edge of the chosen source. It answers with a one-cycle trigger-out pulse, which other boards can use as their own external trigger. It then starts a down-counter loaded with a programmable delay. When the count runs out, the stop output goes high and stays high, freezing the memory. The delay therefore sets where the captured window sits relative to the trigger: with a 16-bit count on a 100 MHz clock it spans roughly 655 µs in 10 ns steps. Further triggers are ignored until software re-arms the block.

Top module: `acq_trig_stop`

## Requirements
- R1: While reset is held, and right after it, `trig_out_o` and `stop_o` are 0 and the block is disarmed: no trigger is accepted until `arm_i` has been seen high on a clock edge.
- R2: When armed, a rising edge of the selected source gives `trig_out_o` high for exactly one cycle. If the input rises before clock edge k, `trig_out_o` is high from edge k+2 to edge k+3 (two synchronizer stages plus one edge-detect stage).
- R3: With `use_ext_i` = 0, the source is the OR over i of (`ch_hit_i[i]` AND `ch_enable_i[i]`). A channel whose enable bit i is 0 never causes a trigger.
- R4: With `use_ext_i` = 1, the source is `ext_trig_i` alone and every `ch_hit_i` bit is ignored. With `use_ext_i` = 0, `ext_trig_i` is ignored.
- R5: Acceptance is edge based: a source held high gives at most one trigger. Re-arming while the source is still high gives no trigger until the source has gone low and risen again.
- R6: `stop_o` rises exactly `delay_i` + 1 cycles after `trig_out_o` rises. `delay_i` is sampled in the acceptance cycle, so later changes have no effect on that event. Both 0 and the all-ones value are valid.
- R7: `stop_o` stays high until `arm_i` is seen on a clock edge. It falls on that same edge and the block is armed again.
- R8: Source edges arriving while disarmed, while counting or while stopped produce no `trig_out_o` pulse and do not change when `stop_o` rises.
- R9: `arm_i` while counting is ignored: the count is neither restarted nor cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_hit_i | input | N_CH | Comparator outputs, asynchronous, one per channel |
| ext_trig_i | input | 1 | External trigger, asynchronous |
| ch_enable_i | input | N_CH | Bit i lets channel i take part in the OR |
| use_ext_i | input | 1 | 1 selects the external trigger as the only source |
| delay_i | input | DLY_W | Post-trigger delay in clock cycles |
| arm_i | input | 1 | Arms the block when disarmed or stopped |
| trig_out_o | output | 1 | One-cycle pulse on each accepted trigger |
| stop_o | output | 1 | High once the delay has elapsed, until re-armed |

## Verification
The bench builds the block with four channels and a 6-bit delay. The narrow delay makes the all-ones delay of 63 reachable in a few dozen cycles, so the end of the counter range is covered along with delay 0. Four channels allow every one of the 16 enable masks to be tried against every single channel. A behavioural model follows the whole board on every clock, including edges that land while the block is disarmed, counting or stopped, and re-arming with the source still high.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_STOP  = 2'd3
  } ctl_state_t;

  // Wide enough for any delay width the block is built with.
  localparam int unsigned MAX_DLY_W = 32;

  // Total cycles from the trigger-out rise to the stop rise.
  function automatic logic [MAX_DLY_W:0] stop_latency(input logic [MAX_DLY_W-1:0] dly);
    return {1'b0, dly} + 1'b1;
  endfunction

  // One down-count step that holds at zero.
  function automatic logic [MAX_DLY_W-1:0] count_step(input logic [MAX_DLY_W-1:0] cnt);
    return (cnt == '0) ? cnt : cnt - 1'b1;
  endfunction

endpackage

// File: rtl/trig_sync_bank.sv
module trig_sync_bank #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else if (STAGES == 1) begin
        chain_q[0] <= async_i[b];
      end else begin
        chain_q <= {chain_q[LAST-1:0], async_i[b]};
      end
    end

    assign sync_o[b] = chain_q[LAST];
  end

endmodule

// File: rtl/trig_source_sel.sv
module trig_source_sel #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] ch_sync_i,
  input  logic            ext_sync_i,
  input  logic [N_CH-1:0] ch_enable_i,
  input  logic            use_ext_i,
  output logic            level_o,
  output logic            rise_o
);

  logic [N_CH-1:0] gated;
  logic            ch_any;
  logic            level_prev_q;

  assign gated   = ch_sync_i & ch_enable_i;
  assign ch_any  = |gated;
  assign level_o = use_ext_i ? ext_sync_i : ch_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev_q <= 1'b0;
    else        level_prev_q <= level_o;
  end

  assign rise_o = level_o & ~level_prev_q;

  // An edge detector can never report two edges in a row (R5).
  p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // An edge implies the source was low one cycle earlier (R5).
  p_edge_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> !$past(level_o));

endmodule

// File: rtl/stop_delay_ctl.sv
module stop_delay_ctl
  import trig_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             arm_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             accept_o,
  output logic             trig_out_o,
  output logic             stop_o
);

  ctl_state_t       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             trig_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept_o = (state_q == ST_ARMED) && rise_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (arm_i) state_d = ST_ARMED;
      ST_ARMED: if (rise_i) begin
        state_d = ST_COUNT;
        cnt_d   = delay_i;
      end
      ST_COUNT: begin
        if (cnt_zero) state_d = ST_STOP;
        cnt_d = DLY_W'(count_step(MAX_DLY_W'(cnt_q)));
      end
      ST_STOP:  if (arm_i) state_d = ST_ARMED;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      trig_q  <= accept_o;
    end
  end

  assign trig_out_o = trig_q;
  assign stop_o     = (state_q == ST_STOP);

  p_trig_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_o |=> !trig_out_o);

  p_trig_opens_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_o |-> (state_q == ST_COUNT) && (cnt_q == $past(delay_i)));

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !cnt_zero) |=> (state_q == ST_COUNT) && (cnt_q == $past(cnt_q) - 1'b1));

  p_stop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !arm_i) |=> stop_o);

  p_rearm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && arm_i) |=> !stop_o);

  p_no_trig_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_ARMED) |=> !trig_out_o);

  p_arm_ignored_counting_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !cnt_zero) |=> (state_q == ST_COUNT));

endmodule

// File: rtl/acq_trig_stop.sv
module acq_trig_stop #(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned DLY_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  ch_hit_i,
  input  logic             ext_trig_i,
  input  logic [N_CH-1:0]  ch_enable_i,
  input  logic             use_ext_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             arm_i,
  output logic             trig_out_o,
  output logic             stop_o
);

  localparam int unsigned SYNC_W = N_CH + 1;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_in;
  logic              sel_level;
  logic              sel_rise;
  logic              accept;

  assign raw_in = {ext_trig_i, ch_hit_i};

  trig_sync_bank #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  trig_source_sel #(
    .N_CH (N_CH)
  ) i_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_sync_i   (sync_in[N_CH-1:0]),
    .ext_sync_i  (sync_in[N_CH]),
    .ch_enable_i (ch_enable_i),
    .use_ext_i   (use_ext_i),
    .level_o     (sel_level),
    .rise_o      (sel_rise)
  );

  stop_delay_ctl #(
    .DLY_W (DLY_W)
  ) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (sel_rise),
    .arm_i      (arm_i),
    .delay_i    (delay_i),
    .accept_o   (accept),
    .trig_out_o (trig_out_o),
    .stop_o     (stop_o)
  );

  // Every trigger-out pulse stems from a source edge one cycle earlier (R2).
  p_trig_from_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out_o |-> $past(sel_rise) && $past(accept));

  // Stop and trigger-out never coincide, as stop needs at least one count cycle (R6).
  p_stop_after_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_out_o && stop_o));

  // With the external source chosen, the selected level follows it alone (R4).
  p_ext_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext_i |-> (sel_level == sync_in[N_CH]));

endmodule

// File: tb/test_acq_trig_stop.sv
module test_acq_trig_stop;

  localparam int N = 4;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] ch_hit = '0;
  logic         ext_trig = 1'b0;
  logic [N-1:0] ch_en = '0;
  logic         use_ext = 1'b0;
  logic [W-1:0] dly = '0;
  logic         arm = 1'b0;
  logic         trig_out, stop;

  acq_trig_stop #(.N_CH(N), .DLY_W(W), .SYNC_STAGES(2)) i_acq_trig_stop (
    .clk(clk), .rst_n(rst_n), .ch_hit_i(ch_hit), .ext_trig_i(ext_trig),
    .ch_enable_i(ch_en), .use_ext_i(use_ext), .delay_i(dly), .arm_i(arm),
    .trig_out_o(trig_out), .stop_o(stop));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int trig_cnt = 0;
  int t_trig = 0;
  int t_stop = 0;
  logic stop_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Behavioural reference: input history queue and an integer mode.
  logic [N:0] hist[$];
  int  m_mode;      // 0 disarmed, 1 armed, 2 counting, 3 stopped
  int  m_left;
  bit  m_prev;
  bit  e_trig, e_stop;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hist = {};
      hist.push_back('0);
      hist.push_back('0);
      m_mode = 0; m_left = 0; m_prev = 0; e_trig = 0; e_stop = 0;
    end else begin
      logic [N:0] old;
      bit lvl, edge_seen;
      hist.push_back({ext_trig, ch_hit});
      old = hist.pop_front();
      lvl = use_ext ? old[N] : |(old[N-1:0] & ch_en);
      edge_seen = lvl && !m_prev;
      m_prev = lvl;
      e_trig = 0;
      case (m_mode)
        0: if (arm) m_mode = 1;
        1: if (edge_seen) begin e_trig = 1; m_left = int'(dly); m_mode = 2; end
        2: if (m_left == 0) m_mode = 3; else m_left--;
        default: if (arm) m_mode = 1;
      endcase
      e_stop = (m_mode == 3);
    end
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(trig_out == e_trig, "R2 model trig_out", int'(trig_out), int'(e_trig));
      chk(stop == e_stop, "R6 model stop", int'(stop), int'(e_stop));
    end
    if (trig_out) begin trig_cnt++; t_trig = cyc; end
    if (stop && !stop_seen) t_stop = cyc;
    stop_seen = stop;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1; wait_cyc(1); arm = 1'b0;
  endtask

  task automatic pulse_ch(input int idx, input int len);
    ch_hit[idx] = 1'b1; wait_cyc(len); ch_hit[idx] = 1'b0;
  endtask

  task automatic pulse_ext(input int len);
    ext_trig = 1'b1; wait_cyc(len); ext_trig = 1'b0;
  endtask

  initial begin
    int base;
    @(negedge clk);
    wait_cyc(3);
    chk(trig_out == 1'b0 && stop == 1'b0, "R1 outputs in reset", int'({trig_out, stop}), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(trig_out == 1'b0 && stop == 1'b0, "R1 outputs after reset", int'({trig_out, stop}), 0);

    // Disarmed after reset: an enabled channel edge is ignored.
    ch_en = 4'hF;
    pulse_ch(0, 3); wait_cyc(10);
    chk(trig_cnt == 0, "R1 R8 no trigger while disarmed", trig_cnt, 0);

    // Basic trigger with delay 5.
    dly = 6'd5; do_arm(); wait_cyc(2);
    pulse_ch(1, 2); wait_cyc(15);
    chk(trig_cnt == 1, "R2 one trigger pulse", trig_cnt, 1);
    chk(t_stop - t_trig == 6, "R6 stop latency delay 5", t_stop - t_trig, 6);
    pulse_ch(2, 2); wait_cyc(12);
    chk(trig_cnt == 1, "R8 trigger ignored while stopped", trig_cnt, 1);
    chk(stop == 1'b1, "R7 stop held", int'(stop), 1);
    do_arm();
    chk(stop == 1'b0, "R7 stop released by arm", int'(stop), 0);

    // Every mask against every channel, delay 0.
    dly = '0;
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < N; i++) begin
        base = trig_cnt;
        ch_en = 4'(m);
        do_arm(); wait_cyc(2);
        pulse_ch(i, 2); wait_cyc(8);
        chk(trig_cnt - base == int'(m[i]), $sformatf("R3 mask %0h ch %0d", m, i),
            trig_cnt - base, int'(m[i]));
      end
    end

    // External source selection.
    ch_en = 4'hF; use_ext = 1'b1; dly = 6'd3;
    do_arm(); wait_cyc(2);
    base = trig_cnt;
    pulse_ch(0, 3); wait_cyc(10);
    chk(trig_cnt == base, "R4 channels ignored in external mode", trig_cnt - base, 0);
    pulse_ext(2); wait_cyc(12);
    chk(trig_cnt == base + 1, "R4 external trigger accepted", trig_cnt - base, 1);
    use_ext = 1'b0; do_arm(); wait_cyc(2);
    pulse_ext(3); wait_cyc(10);
    chk(trig_cnt == base + 1, "R4 external ignored in channel mode", trig_cnt - base, 1);
    pulse_ch(3, 2); wait_cyc(12);
    chk(trig_cnt == base + 2, "R3 channel trigger back in channel mode", trig_cnt - base, 2);

    // Held level gives a single trigger; re-arm while high gives none.
    dly = 6'd2; do_arm(); wait_cyc(2);
    base = trig_cnt;
    ch_hit[0] = 1'b1; wait_cyc(12);
    chk(trig_cnt == base + 1, "R5 held level one trigger", trig_cnt - base, 1);
    do_arm(); wait_cyc(12);
    chk(trig_cnt == base + 1, "R5 no trigger on re-arm with level high", trig_cnt - base, 1);
    chk(stop == 1'b0, "R5 still armed without a new edge", int'(stop), 0);
    ch_hit[0] = 1'b0; wait_cyc(4);
    ch_hit[0] = 1'b1; wait_cyc(12);
    chk(trig_cnt == base + 2, "R5 new edge triggers", trig_cnt - base, 2);
    ch_hit[0] = 1'b0;

    // Delay extremes.
    dly = 6'd0; do_arm(); wait_cyc(2);
    pulse_ch(1, 2); wait_cyc(10);
    chk(t_stop - t_trig == 1, "R6 stop latency delay 0", t_stop - t_trig, 1);
    dly = 6'd63; do_arm(); wait_cyc(2);
    pulse_ch(2, 2); wait_cyc(80);
    chk(t_stop - t_trig == 64, "R6 stop latency delay 63", t_stop - t_trig, 64);

    // Delay change mid-count has no effect.
    dly = 6'd20; do_arm(); wait_cyc(2);
    pulse_ch(1, 2); wait_cyc(5);
    dly = 6'd2; wait_cyc(30);
    chk(t_stop - t_trig == 21, "R6 delay sampled at acceptance", t_stop - t_trig, 21);

    // Arm and a new edge during the count are both ignored.
    dly = 6'd20; do_arm(); wait_cyc(2);
    base = trig_cnt;
    pulse_ch(1, 2); wait_cyc(6);
    do_arm(); wait_cyc(2);
    pulse_ch(2, 2); wait_cyc(30);
    chk(t_stop - t_trig == 21, "R9 arm during count ignored", t_stop - t_trig, 21);
    chk(trig_cnt == base + 1, "R8 edge during count ignored", trig_cnt - base, 1);

    finish_run();
  end

endmodule